// File: doc/BRIEF.md
# Synchronous Receive Hunt and Sync Strip

This block sits between a receive shift register and the receive FIFO of a serial controller. It takes each assembled character as a one-cycle strobe with its byte, and keeps track of whether the receiver is still searching for synchronization. In the byte-synchronous modes it looks for a single sync byte (monosync) or a pair of sync bytes (bisync). In the bit-oriented mode it looks for the frame flag. When it finds the pattern, it clears the sync/hunt status bit and can raise an interrupt pulse.

Once the receiver is synchronized, or at any time in asynchronous mode, characters go on to the FIFO write port. The strip option drops any character whose full byte equals the programmed sync byte. It applies in every mode except bit-oriented, asynchronous mode included, and a dropped character never reaches the CRC path. Each byte that is written carries a tag that tells the CRC engine whether to include it. The hunt state is entered again on command, on a received abort, and when the receiver is enabled.

Top module: `sh_rx_hunt_strip`

## Requirements
- R1: While reset is held and in the first cycle after it, `fifo_wr` and `irq` are 0. `sync_hunt` reads 1 in any synchronous mode (`mode` 1 = monosync, 2 = bisync, 3 = bit-oriented) and 0 in asynchronous mode (`mode` 0).
- R2: In monosync mode, while hunting, a character clears `sync_hunt` on the clock after its strobe if it equals `sync_a`. With `sync6`=1 only bits [5:0] are compared.
- R3: In bisync mode, hunting ends only when a character equal to `sync_b` directly follows a character equal to `sync_a`.
- R4: In bit-oriented mode, hunting ends on the flag byte 8'h7E.
- R5: When hunting ends, `irq` is a pulse exactly one cycle long, in the same cycle that `sync_hunt` falls, if `extst_ie` was 1. Otherwise `irq` stays 0.
- R6: A `hunt_cmd` pulse, an `abort` pulse or a 0-to-1 change of `rx_en` sets `sync_hunt` again from the next clock edge (synchronous modes).
- R7: While hunting, no character is written, including the matching one. The first character after the match is written. In asynchronous mode hunting never blocks writes.
- R8: With `load_inh`=1 and `mode`≠3, a character equal in all 8 bits to `sync_a` is not written, in every mode including asynchronous. `sync6` does not narrow this compare.
- R9: Each written byte appears on `fifo_data` with `fifo_wr`=1 one cycle after its strobe. `crc_tag` is 1 in mode 3, 0 in mode 0, and equal to `crc_en` at the strobe in modes 1 and 2.
- R10: While `rx_en`=0, no character is written and none ends hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| chr_vld | input | 1 | Assembled character strobe |
| chr_data | input | 8 | Assembled character |
| mode | input | 2 | 0 async, 1 monosync, 2 bisync, 3 bit-oriented |
| sync6 | input | 1 | Short (6-bit) monosync pattern for hunting |
| sync_a | input | 8 | Programmed sync byte (hunt pattern and strip byte) |
| sync_b | input | 8 | Second sync byte for bisync hunting |
| load_inh | input | 1 | Strip characters equal to `sync_a` |
| crc_en | input | 1 | Receiver CRC enable |
| hunt_cmd | input | 1 | Command pulse: enter hunt |
| abort | input | 1 | Abort received pulse |
| extst_ie | input | 1 | External/status interrupt enable |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| crc_tag | output | 1 | Include this byte in the CRC |
| sync_hunt | output | 1 | 1 while hunting |
| irq | output | 1 | Sync-achieved interrupt pulse |

## Verification
The assertions assume that `mode`, `load_inh` and `sync_a` hold steady for at least the cycle after a character strobe, so that a registered write can be related to the settings that produced it. The bench changes these settings only at a falling edge, and only after the previous character's result has been sampled. The assertions also assume that `hunt_cmd` and `abort` are single-cycle pulses, and the stimulus only ever drives them for one cycle.

// File: rtl/sh_pkg.sv
package sh_pkg;
   localparam logic [1:0] MD_ASYNC  = 2'd0;
   localparam logic [1:0] MD_MONO   = 2'd1;
   localparam logic [1:0] MD_BISYNC = 2'd2;
   localparam logic [1:0] MD_BITOR  = 2'd3;

   function automatic logic is_sync_mode(input logic [1:0] m);
      return m != MD_ASYNC;
   endfunction
endpackage

// File: rtl/sh_sync_match.sv
module sh_sync_match #(
   parameter int DW        = 8,
   parameter int SHORT_W   = 6,
   parameter bit BISYNC_EN = 1'b1,
   parameter logic [DW-1:0] FLAG = 8'h7E
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          enter,
   input  logic [DW-1:0] chr,
   input  logic [1:0]    mode,
   input  logic          sync6,
   input  logic [DW-1:0] sync_a,
   input  logic [DW-1:0] sync_b,
   output logic          match
);
   import sh_pkg::*;

   logic mono_hit;
   logic pair_hit;
   logic flag_hit;

   always_comb begin
      if (sync6) mono_hit = chr[SHORT_W-1:0] == sync_a[SHORT_W-1:0];
      else       mono_hit = chr == sync_a;
   end

   assign flag_hit = chr == FLAG;

   generate
      if (BISYNC_EN) begin : g_pair
         logic prev_a;
         always_ff @(posedge clk) begin
            if (!rst_n)     prev_a <= 1'b0;
            else if (enter) prev_a <= 1'b0;
            else if (take)  prev_a <= chr == sync_a;
         end
         assign pair_hit = prev_a && (chr == sync_b);
      end else begin : g_nopair
         assign pair_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         MD_MONO:   match = mono_hit;
         MD_BISYNC: match = pair_hit;
         MD_BITOR:  match = flag_hit;
         default:   match = 1'b0;
      endcase
   end
endmodule

// File: rtl/sh_hunt_ctl.sv
module sh_hunt_ctl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_en,
   input  logic       take,
   input  logic       match,
   input  logic [1:0] mode,
   input  logic       hunt_cmd,
   input  logic       abort,
   input  logic       extst_ie,
   output logic       enter,
   output logic       hunting,
   output logic       irq
);
   import sh_pkg::*;

   logic hunt_q;
   logic rx_en_q;

   assign enter   = hunt_cmd | abort | (rx_en & ~rx_en_q);
   assign hunting = hunt_q & is_sync_mode(mode);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hunt_q  <= 1'b1;
         rx_en_q <= 1'b0;
         irq     <= 1'b0;
      end else begin
         rx_en_q <= rx_en;
         irq     <= 1'b0;
         if (enter) begin
            hunt_q <= 1'b1;
         end else if (hunting && take && match) begin
            hunt_q <= 1'b0;
            irq    <= extst_ie;
         end
      end
   end
endmodule

// File: rtl/sh_load_gate.sv
module sh_load_gate #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          hunting,
   input  logic          enter,
   input  logic [DW-1:0] chr,
   input  logic [1:0]    mode,
   input  logic [DW-1:0] sync_a,
   input  logic          load_inh,
   input  logic          crc_en,
   output logic          fifo_wr,
   output logic [DW-1:0] fifo_data,
   output logic          crc_tag
);
   import sh_pkg::*;

   logic strip;
   logic pass;
   logic tag_d;

   assign strip = load_inh && (mode != MD_BITOR) && (chr == sync_a);
   assign pass  = take && !hunting && !enter && !strip;

   always_comb begin
      unique case (mode)
         MD_BITOR: tag_d = 1'b1;
         MD_ASYNC: tag_d = 1'b0;
         default:  tag_d = crc_en;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fifo_wr   <= 1'b0;
         fifo_data <= '0;
         crc_tag   <= 1'b0;
      end else begin
         fifo_wr <= pass;
         if (pass) begin
            fifo_data <= chr;
            crc_tag   <= tag_d;
         end
      end
   end
endmodule

// File: rtl/sh_rx_hunt_strip.sv
module sh_rx_hunt_strip #(
   parameter int DW        = 8,
   parameter int SHORT_W   = 6,
   parameter bit BISYNC_EN = 1'b1,
   parameter logic [DW-1:0] FLAG = 8'h7E
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_en,
   input  logic          chr_vld,
   input  logic [DW-1:0] chr_data,
   input  logic [1:0]    mode,
   input  logic          sync6,
   input  logic [DW-1:0] sync_a,
   input  logic [DW-1:0] sync_b,
   input  logic          load_inh,
   input  logic          crc_en,
   input  logic          hunt_cmd,
   input  logic          abort,
   input  logic          extst_ie,
   output logic          fifo_wr,
   output logic [DW-1:0] fifo_data,
   output logic          crc_tag,
   output logic          sync_hunt,
   output logic          irq
);
   generate
      if (SHORT_W < 1 || SHORT_W >= DW) begin : g_bad_short
         $error("SHORT_W must lie between 1 and DW-1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW too small");
      end
   endgenerate

   logic take;
   logic match;
   logic enter;
   logic hunting;

   assign take      = chr_vld & rx_en;
   assign sync_hunt = hunting;

   sh_sync_match #(.DW(DW), .SHORT_W(SHORT_W), .BISYNC_EN(BISYNC_EN), .FLAG(FLAG)) u_match (
      .clk(clk), .rst_n(rst_n), .take(take), .enter(enter), .chr(chr_data),
      .mode(mode), .sync6(sync6), .sync_a(sync_a), .sync_b(sync_b), .match(match));

   sh_hunt_ctl u_hunt (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .take(take), .match(match),
      .mode(mode), .hunt_cmd(hunt_cmd), .abort(abort), .extst_ie(extst_ie),
      .enter(enter), .hunting(hunting), .irq(irq));

   sh_load_gate #(.DW(DW)) u_gate (
      .clk(clk), .rst_n(rst_n), .take(take), .hunting(hunting), .enter(enter),
      .chr(chr_data), .mode(mode), .sync_a(sync_a), .load_inh(load_inh),
      .crc_en(crc_en), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .crc_tag(crc_tag));
endmodule

// File: rtl/sh_rx_hunt_strip_chk.sv
module sh_rx_hunt_strip_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_en,
   input logic          chr_vld,
   input logic [1:0]    mode,
   input logic [DW-1:0] sync_a,
   input logic          load_inh,
   input logic          abort,
   input logic          hunt_cmd,
   input logic          extst_ie,
   input logic          fifo_wr,
   input logic [DW-1:0] fifo_data,
   input logic          crc_tag,
   input logic          sync_hunt,
   input logic          irq
);
   AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> $past(chr_vld && rx_en)); // R10
   AST_NO_SYNC_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> !($past(load_inh) && $past(mode) != 2'd3 && fifo_data == $past(sync_a))); // R8
   AST_TAG_BITOR: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && $past(mode) == 2'd3) |-> crc_tag); // R9
   AST_TAG_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr && $past(mode) == 2'd0) |-> !crc_tag); // R9
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R5
   AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(extst_ie) && !sync_hunt)); // R5
   AST_REENTER_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ((abort || hunt_cmd) && mode != 2'd0) |=> (sync_hunt || mode == 2'd0)); // R6
endmodule

bind sh_rx_hunt_strip sh_rx_hunt_strip_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .chr_vld(chr_vld), .mode(mode),
   .sync_a(sync_a), .load_inh(load_inh), .abort(abort), .hunt_cmd(hunt_cmd),
   .extst_ie(extst_ie), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .crc_tag(crc_tag),
   .sync_hunt(sync_hunt), .irq(irq));

// File: tb/sim_sh_rx_hunt_strip.sv
`timescale 1ns/1ps
module sim_sh_rx_hunt_strip;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b1;
   logic       chr_vld = 1'b0;
   logic [7:0] chr_data = '0;
   logic [1:0] mode = 2'd1;
   logic       sync6 = 1'b0;
   logic [7:0] sync_a = 8'h16;
   logic [7:0] sync_b = 8'h99;
   logic       load_inh = 1'b0;
   logic       crc_en = 1'b0;
   logic       hunt_cmd = 1'b0;
   logic       abort = 1'b0;
   logic       extst_ie = 1'b0;
   logic       fifo_wr;
   logic [7:0] fifo_data;
   logic       crc_tag;
   logic       sync_hunt;
   logic       irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sh_rx_hunt_strip u0 (.*);

   // fields: mode[14:13] inh[12] crc[11] s6[10] data[9:2] wr[1] tag[0]
   localparam logic [14:0] VEC [10] = '{
      {2'd1, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b1},
      {2'd1, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b0},
      {2'd1, 1'b1, 1'b1, 1'b0, 8'h16, 1'b0, 1'b0},
      {2'd1, 1'b1, 1'b1, 1'b1, 8'h56, 1'b1, 1'b1},
      {2'd0, 1'b1, 1'b1, 1'b0, 8'h16, 1'b0, 1'b0},
      {2'd0, 1'b0, 1'b1, 1'b0, 8'h16, 1'b1, 1'b0},
      {2'd3, 1'b1, 1'b0, 1'b0, 8'h16, 1'b1, 1'b1},
      {2'd2, 1'b0, 1'b1, 1'b0, 8'h16, 1'b1, 1'b1},
      {2'd2, 1'b1, 1'b0, 1'b0, 8'h16, 1'b0, 1'b0},
      {2'd0, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d);
      @(negedge clk);
      chr_vld  = 1'b1;
      chr_data = d;
      @(negedge clk);
      chr_vld  = 1'b0;
   endtask

   task automatic pulse_hunt();
      @(negedge clk);
      hunt_cmd = 1'b1;
      @(negedge clk);
      hunt_cmd = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "sync_hunt in reset", {7'd0, sync_hunt}, 8'd1);
      chk("R1", "fifo_wr in reset", {7'd0, fifo_wr}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "sync_hunt after reset", {7'd0, sync_hunt}, 8'd1);
      chk("R1", "irq after reset", {7'd0, irq}, 8'd0);
      mode = 2'd0;
      #1 chk("R1", "sync_hunt async", {7'd0, sync_hunt}, 8'd0);
      mode = 2'd1;

      // R7: hunting blocks writes, match clears hunt with irq (R5)
      send(8'hA5);
      chk("R7", "no write while hunting", {7'd0, fifo_wr}, 8'd0);
      chk("R2", "non-sync keeps hunt", {7'd0, sync_hunt}, 8'd1);
      extst_ie = 1'b1;
      send(8'h16);
      chk("R2", "sync byte clears hunt", {7'd0, sync_hunt}, 8'd0);
      chk("R5", "irq on sync", {7'd0, irq}, 8'd1);
      chk("R7", "matching byte not written", {7'd0, fifo_wr}, 8'd0);
      @(negedge clk);
      chk("R5", "irq one cycle", {7'd0, irq}, 8'd0);
      extst_ie = 1'b0;

      // vector table, receiver synchronized
      for (int i = 0; i < 10; i++) begin
         mode     = VEC[i][14:13];
         load_inh = VEC[i][12];
         crc_en   = VEC[i][11];
         sync6    = VEC[i][10];
         send(VEC[i][9:2]);
         chk("R8", $sformatf("vec%0d write", i), {7'd0, fifo_wr}, {7'd0, VEC[i][1]});
         if (VEC[i][1]) begin
            chk("R9", $sformatf("vec%0d data", i), fifo_data, VEC[i][9:2]);
            chk("R9", $sformatf("vec%0d tag", i), {7'd0, crc_tag}, {7'd0, VEC[i][0]});
         end
      end
      load_inh = 1'b0;
      crc_en   = 1'b0;

      // R2 short compare
      mode = 2'd1;
      sync6 = 1'b1;
      pulse_hunt();
      chk("R6", "hunt_cmd sets hunt", {7'd0, sync_hunt}, 8'd1);
      send(8'h56);
      chk("R2", "6-bit match clears", {7'd0, sync_hunt}, 8'd0);
      sync6 = 1'b0;
      pulse_hunt();
      send(8'h56);
      chk("R2", "8-bit no match", {7'd0, sync_hunt}, 8'd1);

      // R3 bisync pair
      mode = 2'd2;
      pulse_hunt();
      send(8'h99);
      chk("R3", "second byte alone", {7'd0, sync_hunt}, 8'd1);
      send(8'h16);
      chk("R3", "first byte alone", {7'd0, sync_hunt}, 8'd1);
      send(8'h99);
      chk("R3", "pair clears", {7'd0, sync_hunt}, 8'd0);
      send(8'h42);
      chk("R7", "first byte after sync written", {7'd0, fifo_wr}, 8'd1);
      chk("R7", "first byte data", fifo_data, 8'h42);

      // R4 flag, irq disabled (R5)
      mode = 2'd3;
      pulse_hunt();
      send(8'h16);
      chk("R4", "non-flag keeps hunt", {7'd0, sync_hunt}, 8'd1);
      send(8'h7E);
      chk("R4", "flag clears", {7'd0, sync_hunt}, 8'd0);
      chk("R5", "irq masked", {7'd0, irq}, 8'd0);

      // R6 abort
      @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      chk("R6", "abort sets hunt", {7'd0, sync_hunt}, 8'd1);

      // R10 and R6 enable edge
      send(8'h7E);
      rx_en = 1'b0;
      send(8'h33);
      chk("R10", "no write while disabled", {7'd0, fifo_wr}, 8'd0);
      chk("R10", "still synchronized", {7'd0, sync_hunt}, 8'd0);
      send(8'h7E);
      rx_en = 1'b1;
      @(negedge clk);
      chk("R6", "enable edge sets hunt", {7'd0, sync_hunt}, 8'd1);

      // R7 async ignores hunt state
      mode = 2'd0;
      send(8'h77);
      chk("R7", "async writes", {7'd0, fifo_wr}, 8'd1);
      chk("R9", "async data", fifo_data, 8'h77);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule